// File: doc/BRIEF.md
# Address-Indexed Register and Word Store

This block keeps three kinds of 8-bit state: an address register, a data register, and a bank of eight data words. The address register also picks which word of the bank is read and written. A single 8-bit write value arrives each cycle together with three enable flags. Each flag selects one destination: the address register, the data register, or the word that the address register currently points at. Any mix of the flags can be set in one cycle, and every selected destination takes the same value at the same clock edge.

All three values are visible at the outputs at all times. The word output is a combinational read, so it follows the address register with no extra cycle. Surrounding logic, such as a small processor datapath, computes the write value and the flags. This block only holds the state.

Top module: `addr_word_store`

## Requirements
- R1: A synchronous reset, sampled at a rising clock edge, clears the address register, the data register and all eight words to 0.
- R2: With `load_addr` set at a rising edge, `addr_out` equals `wr_val` after that edge. With `load_addr` clear, `addr_out` keeps its value.
- R3: With `load_data` set at a rising edge, `data_out` equals `wr_val` after that edge. With `load_data` clear, `data_out` keeps its value.
- R4: With `load_word` set, the word whose index equals bits [2:0] of the address register takes `wr_val`. The other seven words do not change.
- R5: Any combination of the three flags writes the same `wr_val` into every selected destination at the same edge.
- R6: With all three flags at 0, no stored value changes and `wr_val` has no effect.
- R7: When `load_word` and `load_addr` are both set in one cycle, the word write uses the address register value from before that edge.
- R8: `word_out` always shows the word indexed by the current address register, and it changes in the same cycle that the address register changes.
- R9: Only bits [2:0] of the address register form the word index. Bits [7:3] do not affect which word is read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_val | input | 8 | Value written into the selected destinations |
| load_addr | input | 1 | Write `wr_val` into the address register |
| load_data | input | 1 | Write `wr_val` into the data register |
| load_word | input | 1 | Write `wr_val` into the word indexed by the address register |
| addr_out | output | 8 | Current address register |
| data_out | output | 8 | Current data register |
| word_out | output | 8 | Word indexed by bits [2:0] of the address register |

## Verification
The hardest case to reach from the ports is a write to the word bank in the same cycle as an address load. Only the old address may be used, and the word written cannot be seen afterwards unless the address is moved back to it. The bench sweeps all eight flag combinations with changing values. After each step it checks all outputs against a model that takes the word index before the address update. It then walks the address register through every index, including values with the upper bits set, and reads back the whole bank. This also shows that no other word was touched.

// File: rtl/aws_pkg.sv
package aws_pkg;
  localparam int unsigned AWS_DATA_W = 8;
  localparam int unsigned AWS_DEPTH  = 8;

  typedef struct packed {
    logic addr;
    logic data;
    logic word;
  } aws_sel_t;
endpackage

// File: rtl/aws_hold_reg.sv
module aws_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q)); // R6
  AST_LOAD_WHEN_EN: assert property (@(posedge clk) disable iff (rst)
    en |=> q == $past(d)); // R5
endmodule

// File: rtl/aws_word_bank.sv
module aws_word_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  function automatic logic [DEPTH-1:0] idx_to_onehot(input logic [IDX_W-1:0] ix);
    logic [DEPTH-1:0] v;
    v = '0;
    v[ix] = 1'b1;
    return v;
  endfunction

  logic [DEPTH-1:0]             word_we;
  logic [DEPTH-1:0][DATA_W-1:0] words;

  assign word_we = we ? idx_to_onehot(widx) : '0;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    aws_hold_reg #(.W(DATA_W)) u_word (
      .clk (clk),
      .rst (rst),
      .en  (word_we[gi]),
      .d   (wdata),
      .q   (words[gi])
    );
  end

  assign rdata = words[ridx];

  AST_ONE_WORD_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(word_we)); // R4
  AST_WORD_TAKES_VALUE: assert property (@(posedge clk) disable iff (rst)
    we |=> words[$past(widx)] == $past(wdata)); // R4
  AST_BANK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(words)); // R6
endmodule

// File: rtl/addr_word_store.sv
module addr_word_store #(
  parameter int unsigned DATA_W = aws_pkg::AWS_DATA_W,
  parameter int unsigned DEPTH  = aws_pkg::AWS_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              load_addr,
  input  logic              load_data,
  input  logic              load_word,
  output logic [DATA_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] word_out
);
  aws_pkg::aws_sel_t sel;
  logic [IDX_W-1:0]  cur_idx;

  assign sel     = '{addr: load_addr, data: load_data, word: load_word};
  assign cur_idx = addr_out[IDX_W-1:0];

  aws_hold_reg #(.W(DATA_W)) u_addr (
    .clk (clk), .rst (rst), .en (sel.addr), .d (wr_val), .q (addr_out)
  );

  aws_hold_reg #(.W(DATA_W)) u_data (
    .clk (clk), .rst (rst), .en (sel.data), .d (wr_val), .q (data_out)
  );

  aws_word_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (sel.word),
    .widx  (cur_idx),
    .wdata (wr_val),
    .ridx  (cur_idx),
    .rdata (word_out)
  );

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_addr |=> addr_out == $past(wr_val)); // R2
  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_data |=> data_out == $past(wr_val)); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_data |=> $stable(data_out)); // R3
  AST_OLD_INDEX_WRITE: assert property (@(posedge clk) disable iff (rst)
    (load_word && load_addr && !load_data) |=>
      ($past(addr_out[IDX_W-1:0]) != addr_out[IDX_W-1:0]) || (word_out == $past(wr_val))); // R7
endmodule

// File: tb/addr_word_store_tb.sv
module addr_word_store_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wr_val = '0;
  logic       load_addr = 1'b0, load_data = 1'b0, load_word = 1'b0;
  logic [7:0] addr_out, data_out, word_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_a, m_d;
  logic [7:0] m_mem [8];
  logic [7:0] lcg = 8'h5b;

  always #10 clk = ~clk;

  addr_word_store u_dut (
    .clk(clk), .rst(rst), .wr_val(wr_val),
    .load_addr(load_addr), .load_data(load_data), .load_word(load_word),
    .addr_out(addr_out), .data_out(data_out), .word_out(word_out)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "addr_out", addr_out, m_a);
    chk(req, "data_out", data_out, m_d);
    chk(req, "word_out", word_out, m_mem[m_a[2:0]]);
  endtask

  // inputs set after a falling edge, outputs sampled at the next falling edge
  task automatic step(input logic [7:0] v, input logic fa, input logic fd, input logic fw);
    wr_val = v; load_addr = fa; load_data = fd; load_word = fw;
    @(posedge clk);
    if (fw) m_mem[m_a[2:0]] = v;  // old address index (R7)
    if (fa) m_a = v;
    if (fd) m_d = v;
    @(negedge clk);
    load_addr = 1'b0; load_data = 1'b0; load_word = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    m_a = '0; m_d = '0;
    for (int i = 0; i < 8; i++) m_mem[i] = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // walk A through every index; upper bits set by hi (R8, R9)
  task automatic readback(input string req, input logic [4:0] hi);
    for (int i = 0; i < 8; i++) begin
      step({hi, i[2:0]}, 1'b1, 1'b0, 1'b0);
      chk(req, "readback word", word_out, m_mem[i]);
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check_all("R1");
    readback("R1", 5'd0);

    // fill the bank at each index with distinct values (R4)
    for (int i = 0; i < 8; i++) begin
      step(8'(i), 1'b1, 1'b0, 1'b0);
      step(8'(8'h30 + i * 7), 1'b0, 1'b0, 1'b1);
      check_all("R4");
    end
    readback("R4", 5'd0);

    // sweep every flag combination with changing values (R2 R3 R5 R6 R7)
    for (int rep = 0; rep < 24; rep++) begin
      for (int f = 0; f < 8; f++) begin
        lcg = lcg * 8'd29 + 8'd71;
        step(lcg, f[0], f[1], f[2]);
        if (f == 0) check_all("R6");
        else if (f == 1) check_all("R2");
        else if (f == 2) check_all("R3");
        else if (f == 5 || f == 7) check_all("R7");
        else check_all("R5");
      end
      if (rep % 6 == 5) readback("R7", 5'(rep));
    end

    // high address bits ignored for index (R9)
    readback("R9", 5'b10110);
    step(8'hf9, 1'b1, 1'b0, 1'b0);
    step(8'hc4, 1'b0, 1'b0, 1'b1);
    step(8'h01, 1'b1, 1'b0, 1'b0);
    step(8'h11, 1'b1, 1'b0, 1'b0);
    check_all("R9");
    step(8'h01, 1'b1, 1'b0, 1'b0);
    chk("R9", "word at 1 via 0x01", word_out, m_mem[1]);

    // same-cycle follow of word_out after address load (R8)
    step(8'h03, 1'b1, 1'b0, 1'b0);
    chk("R8", "word_out follows A", word_out, m_mem[3]);

    // reset mid-run clears everything (R1)
    do_reset();
    check_all("R1");
    readback("R1", 5'b11111);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule